// File: doc/BRIEF.md
# Split-Field Control and Status Register Bank

This block is a bank of control and status fields behind a plain synchronous word bus. The bus word is narrower than some fields. Narrow fields share one bus word, each at a fixed bit offset. A field wider than the word is cut into word-sized chunks at consecutive addresses. The most significant chunk sits at the lowest address, and the top chunk is padded with zeros up to a whole word.

Each field has one access rule for the bus side and one for the device side: read-only, write-only or read-write. A field the device may load has a data input and a load strobe. A field that is bus read-only and device write-only has no flop at all; a bus read returns the device input live. A wide field can be made atomic. Its upper chunks then go into hold flops, and storage changes in one cycle, when the lowest chunk is written. A raw word passes bus strobes and write data straight to the device and returns a device value on read.

The default map uses 8-bit words: control and status at word 0, a 12-bit counter at words 1..2, a 20-bit atomic field at words 3..5, a write-only key at word 6 and the raw word at word 7.

Top module: `csr_bank`

## Requirements
- R1: After reset, ctrl_o is 5'h15, cnt_o is 0, atm_o is 20'h5A3C1, key_o is 0 and rdata_o is 0.
- R2: rdata_o, in the cycle after rd_i is high, shows the word at addr_i as it was before that edge. It is 0 in the cycle after rd_i is low. Unmapped addresses (8 and above) read 0.
- R3: Word 0 packs ctrl in bits [4:0] and stat in bits [7:5]. The stat bits read the live stat_i, and bus writes leave them with no effect.
- R4: The key field at word 6 reads 0 on the bus. A bus write loads all 8 bits into key_o by the next cycle.
- R5: The 12-bit counter reads bits [11:8] in the low four bits of word 1, with the upper bits 0, and bits [7:0] at word 2.
- R6: A bus write to word 1 or word 2 updates only that chunk of cnt_o, in the next cycle.
- R7: Bus writes to words 3 and 4 leave atm_o unchanged. A write to word 5 sets atm_o to {bits [3:0] last written to word 3, last word written to word 4, new data} in the next cycle.
- R8: Reads of words 3..5 return the live atm storage ({0000, bits [19:16]}, [15:8], [7:0]), never the held chunks.
- R9: When cnt_we_i is high, cnt_o takes cnt_i in the next cycle, even if a bus write to word 1 or 2 comes in the same cycle.
- R10: raw_rd_o equals rd_i with addr_i == 7, and raw_wr_o equals we_i with addr_i == 7, both in the same cycle. raw_wdata_o equals wdata_i. A read of word 7 returns raw_rdata_i.
- R11: A bus write to word 0 loads wdata_i[4:0] into ctrl_o in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_i | input | 1 | Bus read request |
| we_i | input | 1 | Bus write enable |
| addr_i | input | 4 | Bus word address |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Registered bus read data |
| ctrl_o | output | 5 | Control field value to the device |
| stat_i | input | 3 | Status value from the device (no storage) |
| cnt_o | output | 12 | Counter field value |
| cnt_we_i | input | 1 | Device load strobe for the counter |
| cnt_i | input | 12 | Device load data for the counter |
| atm_o | output | 20 | Atomic field value |
| key_o | output | 8 | Key field value (bus write-only) |
| raw_rd_o | output | 1 | Raw word read strobe |
| raw_wr_o | output | 1 | Raw word write strobe |
| raw_wdata_o | output | 8 | Raw word write data |
| raw_rdata_i | input | 8 | Raw word read value from the device |

## Verification
Two counter updates can land on the same clock edge: a device load through cnt_we_i and a bus chunk write to word 1 or 2. The random stimulus raises cnt_we_i often. On half of those cycles it also steers a bus write to a counter word, so both requests reach the same edge. A bench model applies the chunk write first and then lets the device value replace the whole counter, and cnt_o is compared with that model one cycle later. The atomic hold path is compared the same way, including reads taken between hold writes and the commit.

// File: rtl/csr_pkg.sv
package csr_pkg;
  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } acc_e;
endpackage

// File: rtl/csr_field.sv
module csr_field #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int W = 8,
  parameter int BASE = 0,
  parameter int OFS = 0,
  parameter bit ATOMIC = 1'b0,
  parameter csr_pkg::acc_e BUS = csr_pkg::ACC_RW,
  parameter csr_pkg::acc_e DEV = csr_pkg::ACC_RO,
  parameter logic [W-1:0] RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          dev_we_i,
  input  logic [W-1:0]  dev_d_i,
  output logic [W-1:0]  dev_q_o,
  output logic [DW-1:0] rd_o
);
  localparam int NCH = (W + DW - 1) / DW;
  localparam int PW = NCH * DW;
  localparam int HW = (NCH > 1) ? (NCH - 1) * DW : DW;
  localparam bit NOSTORE = (BUS == csr_pkg::ACC_RO) && (DEV == csr_pkg::ACC_WO);
  localparam bit BUS_WR = (BUS != csr_pkg::ACC_RO);
  localparam bit BUS_RD = (BUS != csr_pkg::ACC_WO);
  localparam bit DEV_WR = (DEV != csr_pkg::ACC_RO);
  localparam bit DEV_RD = (DEV != csr_pkg::ACC_WO);
  localparam logic [AW-1:0] LAST = AW'(NCH - 1);

  logic          hit;
  logic [AW-1:0] idx;
  logic          bus_wr;
  logic [W-1:0]  src;
  logic [PW-1:0] rd_pad;

  assign hit    = ({1'b0, addr_i} >= (AW+1)'(BASE)) && ({1'b0, addr_i} < (AW+1)'(BASE + NCH));
  assign idx    = addr_i - AW'(BASE);
  assign bus_wr = BUS_WR && we_i && hit;

  generate
    if (NOSTORE) begin : g_nostore
      logic unused_in;
      assign unused_in = ^{clk_i, rst_ni, wdata_i, dev_we_i, bus_wr};
      assign src     = dev_d_i;
      assign dev_q_o = '0;
    end else begin : g_store
      logic [W-1:0] q, nxt;
      logic         upd;
      logic         unused_in;
      assign unused_in = ^{wdata_i, dev_d_i, dev_we_i};

      if (NCH == 1) begin : g_single
        always_comb begin
          nxt = wdata_i[OFS +: W];
          upd = bus_wr;
        end
      end else if (!ATOMIC) begin : g_plain
        always_comb begin
          logic [PW-1:0] p;
          p = PW'(q);
          for (int k = 0; k < NCH; k++)
            if (idx == AW'(k)) p[(NCH-1-k)*DW +: DW] = wdata_i;
          nxt = p[W-1:0];
          upd = bus_wr;
        end
      end else begin : g_atomic
        logic [HW-1:0] hold;
        logic [PW-1:0] cat;
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) hold <= '0;
          else if (bus_wr && idx != LAST) begin
            for (int k = 0; k < NCH - 1; k++)
              if (idx == AW'(k)) hold[(NCH-2-k)*DW +: DW] <= wdata_i;
          end
        end
        assign cat = {hold, wdata_i};
        assign nxt = cat[W-1:0];
        assign upd = bus_wr && (idx == LAST);

        AST_HOLD_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (bus_wr && idx != LAST && !(DEV_WR && dev_we_i)) |=> $stable(q)); // R7
        AST_COMMIT_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
          (bus_wr && idx == LAST && !(DEV_WR && dev_we_i)) |=> q[DW-1:0] == $past(wdata_i)); // R7
      end

      // device load outranks any coincident bus write
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                 q <= RST;
        else if (DEV_WR && dev_we_i) q <= dev_d_i;
        else if (upd)                q <= nxt;
      end

      if (DEV_WR) begin : g_dev_chk
        AST_DEV_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
          dev_we_i |=> q == $past(dev_d_i)); // R9
      end

      assign src     = q;
      assign dev_q_o = DEV_RD ? q : '0;
    end
  endgenerate

  assign rd_pad = PW'(src);

  always_comb begin
    rd_o = '0;
    if (hit && BUS_RD)
      for (int k = 0; k < NCH; k++)
        if (idx == AW'(k)) rd_o = rd_pad[(NCH-1-k)*DW +: DW] << OFS;
  end
endmodule

// File: rtl/csr_raw.sv
module csr_raw #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int RAW_W = 8,
  parameter int ADDR = 7
) (
  input  logic [AW-1:0]    addr_i,
  input  logic             rd_i,
  input  logic             we_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [RAW_W-1:0] raw_rdata_i,
  output logic             raw_rd_o,
  output logic             raw_wr_o,
  output logic [RAW_W-1:0] raw_wdata_o,
  output logic [DW-1:0]    rd_o
);
  logic hit;
  assign hit         = (addr_i == AW'(ADDR));
  assign raw_rd_o    = rd_i && hit;
  assign raw_wr_o    = we_i && hit;
  assign raw_wdata_o = wdata_i[RAW_W-1:0];
  assign rd_o        = hit ? DW'(raw_rdata_i) : '0;
endmodule

// File: rtl/csr_bank.sv
module csr_bank #(
  parameter int DW = 8,
  parameter int AW = 4,
  parameter int CTRL_W = 5,
  parameter int STAT_W = 3,
  parameter int CNT_W = 12,
  parameter int ATM_W = 20,
  parameter logic [CTRL_W-1:0] CTRL_RST = 5'h15,
  parameter logic [ATM_W-1:0] ATM_RST = 20'h5A3C1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic [CTRL_W-1:0] ctrl_o,
  input  logic [STAT_W-1:0] stat_i,
  output logic [CNT_W-1:0]  cnt_o,
  input  logic              cnt_we_i,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic [ATM_W-1:0]  atm_o,
  output logic [DW-1:0]     key_o,
  output logic              raw_rd_o,
  output logic              raw_wr_o,
  output logic [DW-1:0]     raw_wdata_o,
  input  logic [DW-1:0]     raw_rdata_i
);
  import csr_pkg::*;

  localparam int CNT_BASE = 1;
  localparam int CNT_NCH  = (CNT_W + DW - 1) / DW;
  localparam int ATM_BASE = CNT_BASE + CNT_NCH;
  localparam int ATM_NCH  = (ATM_W + DW - 1) / DW;
  localparam int KEY_ADDR = ATM_BASE + ATM_NCH;
  localparam int RAW_ADDR = KEY_ADDR + 1;

  logic [DW-1:0]     rd_ctrl, rd_stat, rd_cnt, rd_atm, rd_key, rd_raw;
  logic [STAT_W-1:0] stat_q_unused;
  logic [DW-1:0]     rdata_q;

  csr_field #(.DW(DW), .AW(AW), .W(CTRL_W), .BASE(0), .OFS(0), .ATOMIC(1'b0),
              .BUS(ACC_RW), .DEV(ACC_RO), .RST(CTRL_RST)) u_ctrl (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dev_we_i(1'b0), .dev_d_i('0), .dev_q_o(ctrl_o), .rd_o(rd_ctrl));

  csr_field #(.DW(DW), .AW(AW), .W(STAT_W), .BASE(0), .OFS(CTRL_W), .ATOMIC(1'b0),
              .BUS(ACC_RO), .DEV(ACC_WO), .RST('0)) u_stat (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dev_we_i(1'b0), .dev_d_i(stat_i), .dev_q_o(stat_q_unused), .rd_o(rd_stat));

  csr_field #(.DW(DW), .AW(AW), .W(CNT_W), .BASE(CNT_BASE), .OFS(0), .ATOMIC(1'b0),
              .BUS(ACC_RW), .DEV(ACC_RW), .RST('0)) u_cnt (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dev_we_i(cnt_we_i), .dev_d_i(cnt_i), .dev_q_o(cnt_o), .rd_o(rd_cnt));

  csr_field #(.DW(DW), .AW(AW), .W(ATM_W), .BASE(ATM_BASE), .OFS(0), .ATOMIC(1'b1),
              .BUS(ACC_RW), .DEV(ACC_RO), .RST(ATM_RST)) u_atm (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dev_we_i(1'b0), .dev_d_i('0), .dev_q_o(atm_o), .rd_o(rd_atm));

  csr_field #(.DW(DW), .AW(AW), .W(DW), .BASE(KEY_ADDR), .OFS(0), .ATOMIC(1'b0),
              .BUS(ACC_WO), .DEV(ACC_RO), .RST('0)) u_key (
    .clk_i, .rst_ni, .addr_i, .we_i, .wdata_i,
    .dev_we_i(1'b0), .dev_d_i('0), .dev_q_o(key_o), .rd_o(rd_key));

  csr_raw #(.DW(DW), .AW(AW), .RAW_W(DW), .ADDR(RAW_ADDR)) u_raw (
    .addr_i, .rd_i, .we_i, .wdata_i, .raw_rdata_i,
    .raw_rd_o, .raw_wr_o, .raw_wdata_o, .rd_o(rd_raw));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_ctrl | rd_stat | rd_cnt | rd_atm | rd_key | rd_raw;
    else           rdata_q <= '0;
  end
  assign rdata_o = rdata_q;

  logic unused_top;
  assign unused_top = ^stat_q_unused;

  AST_IDLE_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> rdata_o == '0); // R2
  AST_KEY_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == AW'(KEY_ADDR)) |=> rdata_o == '0); // R4
  AST_STAT_LIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && addr_i == '0) |=> rdata_o[DW-1:CTRL_W] == $past(stat_i)); // R3
endmodule

// File: tb/tb_csr_bank.sv
module tb_csr_bank;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        rd = 0, we = 0, cnt_we = 0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0, raw_rdata = '0, key_q, rdata, raw_wdata;
  logic [4:0]  ctrl_q;
  logic [2:0]  stat = '0;
  logic [11:0] cnt_d = '0, cnt_q;
  logic [19:0] atm_q;
  logic        raw_rd, raw_wr;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [4:0]  m_ctrl = 5'h15;
  logic [11:0] m_cnt = '0;
  logic [19:0] m_atm = 20'h5A3C1;
  logic [7:0]  m_hh = '0, m_hm = '0, m_key = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  csr_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .rd_i(rd), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ctrl_o(ctrl_q), .stat_i(stat), .cnt_o(cnt_q), .cnt_we_i(cnt_we),
    .cnt_i(cnt_d), .atm_o(atm_q), .key_o(key_q), .raw_rd_o(raw_rd), .raw_wr_o(raw_wr),
    .raw_wdata_o(raw_wdata), .raw_rdata_i(raw_rdata));

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(logic [3:0] a);
    case (a)
      4'd0: return {stat, m_ctrl};
      4'd1: return {4'b0, m_cnt[11:8]};
      4'd2: return m_cnt[7:0];
      4'd3: return {4'b0, m_atm[19:16]};
      4'd4: return m_atm[15:8];
      4'd5: return m_atm[7:0];
      4'd7: return raw_rdata;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string rd_req(logic [3:0] a);
    case (a)
      4'd0: return "R3";
      4'd1, 4'd2: return "R5";
      4'd3, 4'd4, 4'd5: return "R8";
      4'd6: return "R4";
      4'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  // called at a falling edge; leaves time at the next falling edge
  task automatic step(logic r, logic w, logic [3:0] a, logic [7:0] d,
                      logic cw, logic [11:0] cd, logic [2:0] st, logic [7:0] rr);
    logic [7:0] exp_rd;
    rd = r; we = w; addr = a; wdata = d; cnt_we = cw; cnt_d = cd; stat = st; raw_rdata = rr;
    #1;
    check("R10 raw_rd", raw_rd, r && a == 4'd7);
    check("R10 raw_wr", raw_wr, w && a == 4'd7);
    check("R10 raw_wdata", raw_wdata, d);
    exp_rd = r ? model_read(a) : 8'h00;
    if (w) begin
      case (a)
        4'd0: m_ctrl = d[4:0];
        4'd1: m_cnt[11:8] = d[3:0];
        4'd2: m_cnt[7:0] = d;
        4'd3: m_hh = d;
        4'd4: m_hm = d;
        4'd5: m_atm = {m_hh[3:0], m_hm, d};
        4'd6: m_key = d;
        default: ;
      endcase
    end
    if (cw) m_cnt = cd;
    @(posedge clk);
    @(negedge clk);
    check(r ? rd_req(a) : "R2", rdata, exp_rd);
    check("R11 ctrl_o", ctrl_q, m_ctrl);
    check(cw ? "R9 cnt_o" : "R6 cnt_o", cnt_q, m_cnt);
    check("R7 atm_o", atm_q, m_atm);
    check("R4 key_o", key_q, m_key);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'h1234);
    repeat (3) @(negedge clk);
    check("R1 rdata", rdata, 8'h00);
    check("R1 ctrl", ctrl_q, 5'h15);
    check("R1 cnt", cnt_q, 12'h000);
    check("R1 atm", atm_q, 20'h5A3C1);
    check("R1 key", key_q, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    step(1, 0, 4'd0, 8'h00, 0, 12'h0, 3'b101, 8'h00);   // R1 R3 reset read
    step(1, 1, 4'd0, 8'hFF, 0, 12'h0, 3'b010, 8'h00);   // R3 stat bits ignore write
    step(1, 0, 4'd0, 8'h00, 0, 12'h0, 3'b010, 8'h00);   // R11 ctrl = 1F
    step(0, 1, 4'd1, 8'hF7, 0, 12'h0, 3'b000, 8'h00);   // R6 upper chunk
    step(1, 1, 4'd2, 8'h3C, 0, 12'h0, 3'b000, 8'h00);   // R6 lower chunk
    step(1, 0, 4'd1, 8'h00, 0, 12'h0, 3'b000, 8'h00);   // R5 upper read
    step(1, 1, 4'd3, 8'hA9, 0, 12'h0, 3'b000, 8'h00);   // R7 hold only
    step(1, 1, 4'd4, 8'h42, 0, 12'h0, 3'b000, 8'h00);   // R7 R8 live read
    step(1, 0, 4'd3, 8'h00, 0, 12'h0, 3'b000, 8'h00);   // R8 still reset value
    step(1, 1, 4'd5, 8'h81, 0, 12'h0, 3'b000, 8'h00);   // R7 commit
    step(1, 0, 4'd5, 8'h00, 0, 12'h0, 3'b000, 8'h00);   // R8 after commit
    step(1, 1, 4'd2, 8'h55, 1, 12'hABC, 3'b000, 8'h00); // R9 device wins
    step(1, 1, 4'd6, 8'hC3, 0, 12'h0, 3'b000, 8'h00);   // R4 key write
    step(1, 0, 4'd6, 8'h00, 0, 12'h0, 3'b000, 8'h00);   // R4 reads 0
    step(1, 1, 4'd7, 8'h99, 0, 12'h0, 3'b000, 8'h6E);   // R10 raw
    step(1, 0, 4'd9, 8'h00, 0, 12'h0, 3'b000, 8'h00);   // R2 unmapped

    for (int i = 0; i < 3000; i++) begin
      logic r, w, cw;
      logic [3:0] a;
      r  = 1'($urandom % 2);
      w  = ($urandom % 3) == 0;
      a  = 4'($urandom % 10);
      cw = ($urandom % 6) == 0;
      if (cw && ($urandom % 2) == 1) begin
        w = 1'b1;
        a = 4'd1 + 4'($urandom % 2);
      end
      step(r, w, a, 8'($urandom), cw, 12'($urandom), 3'($urandom), 8'($urandom));
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule